// File: doc/BRIEF.md
# UART DMA and Wake-up Controller

This block is the supplementary control logic placed beside a UART core. It owns an 8-bit control register, written and read through a plain register port, and from it decides how the two active-low DMA request lines are driven from the transmit and receive FIFO fill levels. The DMA mode is taken either from a legacy bit of the FIFO control register or from a two-bit field of this register. The chosen mode decides which request line serves transmit and which serves receive.

The block also watches the RX, CTS and DSR pins for a falling edge while wake-up is armed. It latches a wake-up flag that software reads as a status bit, outside the normal interrupt identification path. It also gates two interrupt requests. The first is the transmit-holding interrupt, which can be restricted to a fully drained transmitter. The second is the DSR change interrupt, which has its own enable.

Top module: `uart_wake_dma_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, both DMA request lines are high (inactive) and the wake-up status is 0.
- R2: A write with `regWr` high updates all 8 register bits on that clock edge, and `regRdData` returns the written value from the next cycle.
- R3: With register bit 0 at 0 the mode follows `fcrDmaBit`: 0 gives mode 00 and 1 gives mode 01.
- R4: With register bit 0 at 1 the mode is register bits 2:1. Mode 00 keeps both lines high. Mode 01 puts TX on line 0 and RX on line 1. Mode 10 puts RX on line 0. Mode 11 puts TX on line 0. In modes 10 and 11, line 1 stays high.
- R5: The TX request is low while `txLevel` is at or below its effective threshold. The RX request is low while `rxLevel` is at or above its effective threshold.
- R6: Register bit 7 (RX) and bit 6 (TX) select single-entry thresholds. When the bit is clear, the threshold input counts in units of 4 entries.
- R7: With register bit 4 set, a falling edge on any of RX, CTS or DSR sets `wakeStatus` and `wakeIrq` within 4 cycles.
- R8: A falling edge that occurs while bit 4 is 0 is ignored, including after bit 4 is later set while the pin stays low.
- R9: The wake-up flag stays set while bit 4 stays 1. Writing bit 4 to 0 clears it on the next cycle.
- R10: With register bit 3 at 0, `thrIrq` follows the TX threshold hit. With bit 3 at 1, it is high only when `txLevel` is 0 and `txShiftEmpty` is 1.
- R11: `dsrIrq` equals `dsrDelta` when register bit 5 is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| fcrDmaBit | input | 1 | Legacy DMA bit from the FIFO control register |
| txLevel | input | LW (7) | TX FIFO fill level |
| rxLevel | input | LW (7) | RX FIFO fill level |
| txThresh | input | LW (7) | TX threshold (entries or groups of 4) |
| rxThresh | input | LW (7) | RX threshold (entries or groups of 4) |
| txShiftEmpty | input | 1 | TX shift register empty |
| dsrDelta | input | 1 | Raw DSR change interrupt request |
| rxPin | input | 1 | Serial receive pin (asynchronous) |
| ctsPin | input | 1 | Clear-to-send pin (asynchronous) |
| dsrPin | input | 1 | Data-set-ready pin (asynchronous) |
| dmaReqN | output | 2 | Active-low DMA request lines |
| thrIrq | output | 1 | Gated transmit-holding interrupt request |
| dsrIrq | output | 1 | Gated DSR change interrupt request |
| wakeIrq | output | 1 | Wake-up interrupt |
| wakeStatus | output | 1 | Wake-up status bit |

## Verification
The assertions check on every cycle that register writes read back, that idle request lines stay high, that a masked DSR or a busy transmitter never raises its interrupt, and that the wake-up flag clears once disarmed and holds while armed. Only the bench scenarios can show how pin edges travel through the synchronizers into the flag. They also show that an edge seen while disarmed leaves no trace after arming, and that threshold scaling and the mode-to-line mapping give the correct request levels across random FIFO levels.

// File: rtl/uwd_pkg.sv
package uwd_pkg;
  typedef enum logic [1:0] {
    DMA_OFF     = 2'b00,
    DMA_SPLIT   = 2'b01,
    DMA_RX_ONLY = 2'b10,
    DMA_TX_ONLY = 2'b11
  } dmaMode_e;

  // control strobes handed from the register side to the datapath
  typedef struct packed {
    dmaMode_e mode;
    logic     wakeArm;
    logic     txEmptyOnly;
    logic     dsrEn;
    logic     rxGran;
    logic     txGran;
  } ctlStrobe_t;

  localparam int BIT_SRC     = 0;
  localparam int BIT_MODE_LO = 1;
  localparam int BIT_THR     = 3;
  localparam int BIT_WAKE    = 4;
  localparam int BIT_DSR     = 5;
  localparam int BIT_TXGRAN  = 6;
  localparam int BIT_RXGRAN  = 7;
endpackage

// File: rtl/uwd_ctrl.sv
module uwd_ctrl
  import uwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  input  logic       fcrDmaBit,
  output logic [7:0] ctlReg,
  output ctlStrobe_t strb
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctlReg <= '0;
    else if (regWr) ctlReg <= regWrData;
  end

  always_comb begin
    if (ctlReg[BIT_SRC]) strb.mode = dmaMode_e'(ctlReg[BIT_MODE_LO +: 2]);
    else                 strb.mode = fcrDmaBit ? DMA_SPLIT : DMA_OFF;
    strb.wakeArm     = ctlReg[BIT_WAKE];
    strb.txEmptyOnly = ctlReg[BIT_THR];
    strb.dsrEn       = ctlReg[BIT_DSR];
    strb.rxGran      = ctlReg[BIT_RXGRAN];
    strb.txGran      = ctlReg[BIT_TXGRAN];
  end
endmodule

// File: rtl/uwd_datapath.sv
module uwd_datapath
  import uwd_pkg::*;
#(
  parameter int LW   = 7,
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strb,
  input  logic [LW-1:0]   txLevel,
  input  logic [LW-1:0]   rxLevel,
  input  logic [LW-1:0]   txThresh,
  input  logic [LW-1:0]   rxThresh,
  input  logic            txShiftEmpty,
  input  logic            dsrDelta,
  input  logic [NPIN-1:0] pinIn,
  output logic [1:0]      dmaReqN,
  output logic            thrIrq,
  output logic            dsrIrq,
  output logic            wakeFlag
);
  localparam int EW = LW + 2;

  logic [EW-1:0] txEff, rxEff;
  logic          txHit, rxHit;

  always_comb begin
    txEff = strb.txGran ? EW'(txThresh) : (EW'(txThresh) << 2);
    rxEff = strb.rxGran ? EW'(rxThresh) : (EW'(rxThresh) << 2);
    txHit = EW'(txLevel) <= txEff;
    rxHit = EW'(rxLevel) >= rxEff;
  end

  always_comb begin
    dmaReqN = 2'b11;
    unique case (strb.mode)
      DMA_SPLIT:   dmaReqN = {~rxHit, ~txHit};
      DMA_RX_ONLY: dmaReqN[0] = ~rxHit;
      DMA_TX_ONLY: dmaReqN[0] = ~txHit;
      default:     dmaReqN = 2'b11;
    endcase
  end

  assign thrIrq = strb.txEmptyOnly ? (txLevel == '0 && txShiftEmpty) : txHit;
  assign dsrIrq = strb.dsrEn & dsrDelta;

  logic [NPIN-1:0] syncA, syncB, lastB;

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b1;
        syncB[g] <= 1'b1;
        lastB[g] <= 1'b1;
      end else begin
        syncA[g] <= pinIn[g];
        syncB[g] <= syncA[g];
        lastB[g] <= syncB[g];
      end
    end
  end

  logic [NPIN-1:0] fallSeen;
  assign fallSeen = lastB & ~syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wakeFlag <= 1'b0;
    else if (!strb.wakeArm) wakeFlag <= 1'b0;
    else if (|fallSeen)     wakeFlag <= 1'b1;
  end
endmodule

// File: rtl/uart_wake_dma_ctrl.sv
module uart_wake_dma_ctrl
  import uwd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWr,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  input  logic          fcrDmaBit,
  input  logic [LW-1:0] txLevel,
  input  logic [LW-1:0] rxLevel,
  input  logic [LW-1:0] txThresh,
  input  logic [LW-1:0] rxThresh,
  input  logic          txShiftEmpty,
  input  logic          dsrDelta,
  input  logic          rxPin,
  input  logic          ctsPin,
  input  logic          dsrPin,
  output logic [1:0]    dmaReqN,
  output logic          thrIrq,
  output logic          dsrIrq,
  output logic          wakeIrq,
  output logic          wakeStatus
);
  ctlStrobe_t strb;
  logic       wakeFlag;

  uwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regWrData(regWrData),
    .fcrDmaBit(fcrDmaBit), .ctlReg(regRdData), .strb(strb)
  );

  uwd_datapath #(.LW(LW), .NPIN(3)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txShiftEmpty(txShiftEmpty), .dsrDelta(dsrDelta),
    .pinIn({dsrPin, ctsPin, rxPin}),
    .dmaReqN(dmaReqN), .thrIrq(thrIrq), .dsrIrq(dsrIrq),
    .wakeFlag(wakeFlag)
  );

  assign wakeIrq    = wakeFlag;
  assign wakeStatus = wakeFlag;
endmodule

// File: rtl/uwd_checker.sv
module uwd_checker #(
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWr,
  input logic [7:0]    regWrData,
  input logic [7:0]    regRdData,
  input logic          fcrDmaBit,
  input logic [LW-1:0] txLevel,
  input logic [1:0]    dmaReqN,
  input logic          thrIrq,
  input logic          dsrIrq,
  input logic          wakeStatus
);
  p_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> regRdData == $past(regWrData));

  p_line1_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((regRdData[0] && regRdData[2:1] != 2'b01) || (!regRdData[0] && !fcrDmaBit)) |-> dmaReqN[1]);

  p_nodma_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[0] && !fcrDmaBit) |-> dmaReqN == 2'b11);

  p_disarm_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[4] |=> !wakeStatus);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeStatus && regRdData[4]) |=> wakeStatus);

  p_dsr_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[5] |-> !dsrIrq);

  p_thr_drained_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[3] && txLevel != '0) |-> !thrIrq);
endmodule

bind uart_wake_dma_ctrl uwd_checker #(.LW(LW)) u_chk (.*);

// File: tb/uart_wake_dma_ctrl_tb.sv
module uart_wake_dma_ctrl_tb;
  localparam int LW = 7;

  logic clk = 0, rstN = 0;
  logic regWr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic fcrDmaBit = 0;
  logic [LW-1:0] txLevel = 0, rxLevel = 0, txThresh = 0, rxThresh = 0;
  logic txShiftEmpty = 0, dsrDelta = 0;
  logic rxPin = 1, ctsPin = 1, dsrPin = 1;
  logic [1:0] dmaReqN;
  logic thrIrq, dsrIrq, wakeIrq, wakeStatus;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  uart_wake_dma_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); regWr = 1; regWrData = v;
    @(negedge clk); regWr = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int effTh(input int th, input bit gran);
    return gran ? th : th * 4;
  endfunction

  function automatic logic [1:0] expReq(input logic [7:0] c, input bit fcr,
                                        input int tl, input int rl, input int tt, input int rt);
    logic [1:0] m;
    bit tH, rH;
    m  = c[0] ? c[2:1] : {1'b0, fcr};
    tH = tl <= effTh(tt, c[6]);
    rH = rl >= effTh(rt, c[7]);
    case (m)
      2'b01:   return {~rH, ~tH};
      2'b10:   return {1'b1, ~rH};
      2'b11:   return {1'b1, ~tH};
      default: return 2'b11;
    endcase
  endfunction

  function automatic bit expThr(input logic [7:0] c, input int tl, input int tt, input bit se);
    return c[3] ? (tl == 0 && se) : (tl <= effTh(tt, c[6]));
  endfunction

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    waitCyc(2);
    // R1: reset state
    chk("R1 reg", regRdData, 8'h00);
    chk("R1 dma", dmaReqN, 2'b11);
    chk("R1 wake", wakeStatus, 0);
    rstN = 1;
    waitCyc(1);

    // R2: readback
    wrReg(8'hA5); chk("R2 readback", regRdData, 8'hA5);
    wrReg(8'h00); chk("R2 readback zero", regRdData, 8'h00);

    // R3: legacy source, directed
    txLevel = 0; rxLevel = 20; txThresh = 2; rxThresh = 1;
    fcrDmaBit = 0; #1 chk("R3 fcr0 no dma", dmaReqN, 2'b11);
    @(negedge clk); fcrDmaBit = 1; #1 chk("R3 fcr1 split", dmaReqN, 2'b00);

    // R4 / R6 directed corners: threshold boundaries
    wrReg(8'b0000_0111); // mode 11, unit-4 thresholds
    @(negedge clk); txLevel = 8; txThresh = 2; #1 chk("R6 tx at 4x boundary", dmaReqN, 2'b10);
    @(negedge clk); txLevel = 9; #1 chk("R6 tx past 4x boundary", dmaReqN, 2'b11);
    wrReg(8'b1000_0101); // mode 10, rx single-entry
    @(negedge clk); rxLevel = 3; rxThresh = 3; #1 chk("R6 rx gran equal", dmaReqN, 2'b10);
    @(negedge clk); rxLevel = 2; #1 chk("R5 rx below", dmaReqN, 2'b11);

    // R4 R5 R6 R10 R11: random
    for (int i = 0; i < 300; i++) begin
      logic [7:0] c;
      c = 8'($urandom) & 8'hEF;
      wrReg(c);
      @(negedge clk);
      fcrDmaBit    = 1'($urandom);
      txLevel      = LW'($urandom_range(0, 64));
      rxLevel      = LW'($urandom_range(0, 64));
      txThresh     = LW'($urandom_range(0, 20));
      rxThresh     = LW'($urandom_range(0, 20));
      txShiftEmpty = 1'($urandom);
      dsrDelta     = 1'($urandom);
      if (i % 5 == 0) txLevel = 0;
      #1;
      chk("R4 R5 R6 dma", dmaReqN,
          expReq(c, fcrDmaBit, txLevel, rxLevel, txThresh, rxThresh));
      chk("R10 thr", thrIrq, expThr(c, txLevel, txThresh, txShiftEmpty));
      chk("R11 dsr", dsrIrq, c[5] & dsrDelta);
    end

    // R7: armed falling edge on RX
    wrReg(8'h10);
    waitCyc(4);
    chk("R7 no spurious", wakeStatus, 0);
    rxPin = 0; waitCyc(2); rxPin = 1;
    waitCyc(3);
    chk("R7 rx edge status", wakeStatus, 1);
    chk("R7 rx edge irq", wakeIrq, 1);
    // R9: sticky, then clear
    waitCyc(6);
    chk("R9 sticky", wakeStatus, 1);
    wrReg(8'h00); waitCyc(1);
    chk("R9 cleared", wakeStatus, 0);

    // R8: edge while disarmed ignored
    ctsPin = 0; waitCyc(5);
    chk("R8 disarmed edge", wakeStatus, 0);
    wrReg(8'h10); waitCyc(5);
    chk("R8 edge before arm ignored", wakeStatus, 0);
    ctsPin = 1; waitCyc(5);
    chk("R8 rising ignored", wakeStatus, 0);

    // R7: DSR edge
    dsrPin = 0; waitCyc(5);
    chk("R7 dsr edge", wakeStatus, 1);
    dsrPin = 1;
    wrReg(8'h00); waitCyc(1);
    chk("R9 cleared again", wakeStatus, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule